// File: doc/BRIEF.md
# Per-Port Address Flush Engine

This block is a sequencer that clears the learned addresses of selected ports from a switch's address table. Software or a control block pulses a start strobe together with a flush mask that has one bit per port. The engine then visits every table index in ascending order. For each index it reads the entry and, if the entry holds an address, applies the flush rules and writes the result back to the same index.

Unicast entries that belong to a flushed port are released. Multicast entries are not dropped outright. Their member list loses the flushed ports, and an entry is released only when the host port is the one member left. Free entries and entries that carry only a VLAN are never written.

The engine owns a single-ported, synchronous-read path into the table memory. It reports progress through a busy level and a one-cycle done pulse.

Top module: `flush_engine`

Table entry layout, least significant bit first, with the default parameters (MAC_W=48, EXT_PORTS=2):
- bits [47:0]: station address
- bits [49:48]: kind, where 0 is free, 1 is address, 2 is VLAN-only and 3 is VLAN-plus-address
- bit 50: group flag, where 1 marks a multicast entry
- bits [53:51]: multicast member list, with bit p standing for port p
- bits [55:54]: unicast owner port number

## Requirements
- R1: Only entries of kind 1 (address) or kind 3 (VLAN-plus-address) are examined. An entry of kind 0 or kind 2 is never written and keeps its content.
- R2: An examined unicast entry (group flag 0) is set to kind 0 when flush mask bit `owner` is set. Every other field stays as it was. An owner value with no matching mask bit (including owner 3 by default) never matches.
- R3: An examined multicast entry whose member list shares no bit with the flush mask is written back unchanged.
- R4: For an examined multicast entry that does overlap the mask, the flushed ports are cleared from the member list. The entry keeps its kind unless R5 applies.
- R5: If the member list left after clearing equals exactly the host-port bit, the entry is set to kind 0 and its member field keeps its old value.
- R6: The host-port bit is bit EXT_PORTS of the member list, which is bit 2 by default.
- R7: Every examined entry is written back exactly once per flush, at the index it was read from. The station address, group flag and owner fields are carried over unchanged.
- R8: A start taken while idle raises busy on the next cycle. Each entry then takes one read cycle followed by one write-slot cycle, so busy stays high for 2*ENTRIES cycles. done is high for exactly one cycle, the cycle after the last write slot, and busy is low in that cycle.
- R9: A start strobe that arrives while busy is ignored. The flush mask captured at the accepted start stays in force until the walk ends.
- R10: While reset is held, busy and done are low and no table read or write is issued.
- R11: A multicast entry whose member list becomes empty stays an address entry with an all-zero member list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_start | input | 1 | Start strobe, taken only while idle |
| flush_mask | input | EXT_PORTS+1 | Ports to flush; bit EXT_PORTS is the host port |
| flush_busy | output | 1 | High while the table walk is running |
| flush_done | output | 1 | One-cycle pulse after the last entry |
| tbl_addr | output | $clog2(ENTRIES) | Table index for the read or the write |
| tbl_rd_en | output | 1 | Read request; data returns on the next cycle |
| tbl_rd_data | input | ENTRY_W | Entry read from the table |
| tbl_wr_en | output | 1 | Write strobe |
| tbl_wr_data | output | ENTRY_W | Entry to write |

## Verification
The hardest case to reach is a multicast entry whose surviving member list is exactly the host bit. This needs a member list that overlaps the mask and also holds the host bit plus only flushed ports. Such entries must be present at the moment a walk passes them, and the second walk must act on entries the first walk has already changed. The bench preloads its table model so that every rule, and its near misses, appears at some index. It runs two flushes back to back with different masks, so the second acts on partly pruned lists. During the second walk it pulses a wider mask in the middle of the run, so an accepted restart would leave a visible mark on particular entries.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [1:0] {
    KIND_FREE      = 2'd0,
    KIND_ADDR      = 2'd1,
    KIND_VLAN      = 2'd2,
    KIND_VLAN_ADDR = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RD   = 2'd1,
    WALK_WR   = 2'd2
  } walk_state_e;

  function automatic logic kind_has_addr(input logic [1:0] kind);
    return (kind == KIND_ADDR) || (kind == KIND_VLAN_ADDR);
  endfunction

endpackage

// File: rtl/flush_walker.sv
module flush_walker #(
  parameter int ENTRIES = 16,
  parameter int PMW = 3,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PMW-1:0]   mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             rd_phase_o,
  output logic             wr_phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PMW-1:0]   mask_q_o
);
  import flush_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  walk_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [PMW-1:0]   mask_q;
  logic             done_q;
  logic             accept;
  logic             at_last;

  assign accept  = start_i && (state_q == WALK_IDLE);
  assign at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        WALK_IDLE: begin
          if (accept) begin
            mask_q  <= mask_i;
            idx_q   <= '0;
            state_q <= WALK_RD;
          end
        end
        WALK_RD: state_q <= WALK_WR;
        WALK_WR: begin
          if (at_last) begin
            state_q <= WALK_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= WALK_RD;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != WALK_IDLE);
  assign done_o     = done_q;
  assign rd_phase_o = (state_q == WALK_RD);
  assign wr_phase_o = (state_q == WALK_WR);
  assign idx_o      = idx_q;
  assign mask_q_o   = mask_q;

endmodule

// File: rtl/flush_entry_xform.sv
module flush_entry_xform #(
  parameter int MAC_W = 48,
  parameter int EXT_PORTS = 2,
  localparam int PMW = EXT_PORTS + 1,
  localparam int PNW = (PMW > 1) ? $clog2(PMW) : 1,
  localparam int KIND_LSB = MAC_W,
  localparam int GRP_BIT = MAC_W + 2,
  localparam int MEM_LSB = MAC_W + 3,
  localparam int OWN_LSB = MEM_LSB + PMW,
  localparam int ENTRY_W = OWN_LSB + PNW
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [PMW-1:0]     mask_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               examined_o
);
  import flush_pkg::*;

  localparam logic [PMW-1:0] HOST_BIT = PMW'(1) << EXT_PORTS;

  function automatic logic owner_hit(input logic [PNW-1:0] owner,
                                     input logic [PMW-1:0] mask);
    logic [PMW-1:0] sel;
    sel = PMW'(1) << owner;
    return |(sel & mask);
  endfunction

  function automatic logic [PMW-1:0] prune(input logic [PMW-1:0] members,
                                           input logic [PMW-1:0] mask);
    return members & ~mask;
  endfunction

  function automatic logic host_only(input logic [PMW-1:0] members);
    return members == HOST_BIT;
  endfunction

  logic [1:0]     kind;
  logic           grp;
  logic [PMW-1:0] members;
  logic [PMW-1:0] left;
  logic [PNW-1:0] owner;

  always_comb begin
    kind       = entry_i[KIND_LSB +: 2];
    grp        = entry_i[GRP_BIT];
    members    = entry_i[MEM_LSB +: PMW];
    owner      = entry_i[OWN_LSB +: PNW];
    left       = prune(members, mask_i);
    examined_o = kind_has_addr(kind);
    entry_o    = entry_i;
    if (examined_o) begin
      if (grp) begin
        if (|(members & mask_i)) begin
          if (host_only(left)) entry_o[KIND_LSB +: 2] = KIND_FREE;
          else                 entry_o[MEM_LSB +: PMW] = left;
        end
      end else if (owner_hit(owner, mask_i)) begin
        entry_o[KIND_LSB +: 2] = KIND_FREE;
      end
    end
  end

endmodule

// File: rtl/flush_engine.sv
module flush_engine #(
  parameter int MAC_W = 48,
  parameter int EXT_PORTS = 2,
  parameter int ENTRIES = 16,
  localparam int PMW = EXT_PORTS + 1,
  localparam int PNW = (PMW > 1) ? $clog2(PMW) : 1,
  localparam int ENTRY_W = MAC_W + 3 + PMW + PNW,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_start,
  input  logic [PMW-1:0]     flush_mask,
  output logic               flush_busy,
  output logic               flush_done,
  output logic [IDX_W-1:0]   tbl_addr,
  output logic               tbl_rd_en,
  input  logic [ENTRY_W-1:0] tbl_rd_data,
  output logic               tbl_wr_en,
  output logic [ENTRY_W-1:0] tbl_wr_data
);

  logic           walk_rd;
  logic           walk_wr;
  logic [PMW-1:0] walk_mask;
  logic           entry_examined;
  logic [ENTRY_W-1:0] entry_next;

  flush_walker #(.ENTRIES(ENTRIES), .PMW(PMW)) walker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (flush_start),
    .mask_i    (flush_mask),
    .busy_o    (flush_busy),
    .done_o    (flush_done),
    .rd_phase_o(walk_rd),
    .wr_phase_o(walk_wr),
    .idx_o     (tbl_addr),
    .mask_q_o  (walk_mask)
  );

  flush_entry_xform #(.MAC_W(MAC_W), .EXT_PORTS(EXT_PORTS)) xform_i (
    .entry_i   (tbl_rd_data),
    .mask_i    (walk_mask),
    .entry_o   (entry_next),
    .examined_o(entry_examined)
  );

  assign tbl_rd_en   = walk_rd;
  assign tbl_wr_en   = walk_wr && entry_examined;
  assign tbl_wr_data = entry_next;

endmodule

// File: rtl/flush_engine_chk.sv
module flush_engine_chk #(
  parameter int MAC_W = 48,
  parameter int EXT_PORTS = 2,
  parameter int ENTRIES = 16,
  localparam int PMW = EXT_PORTS + 1,
  localparam int PNW = (PMW > 1) ? $clog2(PMW) : 1,
  localparam int KIND_LSB = MAC_W,
  localparam int GRP_BIT = MAC_W + 2,
  localparam int MEM_LSB = MAC_W + 3,
  localparam int OWN_LSB = MEM_LSB + PMW,
  localparam int ENTRY_W = OWN_LSB + PNW,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [IDX_W-1:0]   addr,
  input logic               rd_en,
  input logic [ENTRY_W-1:0] rd_data,
  input logic               wr_en,
  input logic [ENTRY_W-1:0] wr_data,
  input logic [PMW-1:0]     mask_q
);
  localparam logic [PMW-1:0] HOST_BIT = PMW'(1) << EXT_PORTS;

  logic [1:0]     rd_kind, wr_kind;
  logic           wr_grp;
  logic [PMW-1:0] rd_mem, wr_mem;
  logic [PNW-1:0] wr_own;
  logic [PMW-1:0] own_sel;

  assign rd_kind = rd_data[KIND_LSB +: 2];
  assign wr_kind = wr_data[KIND_LSB +: 2];
  assign wr_grp  = wr_data[GRP_BIT];
  assign rd_mem  = rd_data[MEM_LSB +: PMW];
  assign wr_mem  = wr_data[MEM_LSB +: PMW];
  assign wr_own  = wr_data[OWN_LSB +: PNW];
  assign own_sel = PMW'(1) << wr_own;

  // R10
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !wr_en));

  // R8
  a_r8_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  a_r7_same_index: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rd_en) && (addr == $past(addr))));
  a_r7_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[MAC_W-1:0] == rd_data[MAC_W-1:0]) &&
              (wr_grp == rd_data[GRP_BIT]) &&
              (wr_own == rd_data[OWN_LSB +: PNW]));

  // R1
  a_r1_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rd_kind == 2'd1 || rd_kind == 2'd3));

  // R2
  a_r2_ucast_survivor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_grp && wr_kind != 2'd0) |-> ((own_sel & mask_q) == '0));

  // R4
  a_r4_mcast_pruned: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grp && wr_kind != 2'd0) |-> ((wr_mem & mask_q) == '0));

  // R5
  a_r5_host_only_freed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grp && wr_kind == 2'd0) |->
      (((rd_mem & ~mask_q) == HOST_BIT) && (wr_mem == rd_mem)));

  // R9
  a_r9_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_q));
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !(wr_en && addr == IDX_W'(ENTRIES - 1))) |=> busy);

endmodule

bind flush_engine flush_engine_chk #(
  .MAC_W(MAC_W), .EXT_PORTS(EXT_PORTS), .ENTRIES(ENTRIES)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (flush_start),
  .busy   (flush_busy),
  .done   (flush_done),
  .addr   (tbl_addr),
  .rd_en  (tbl_rd_en),
  .rd_data(tbl_rd_data),
  .wr_en  (tbl_wr_en),
  .wr_data(tbl_wr_data),
  .mask_q (walk_mask)
);

// File: tb/flush_engine_tb_top.sv
`timescale 1ns/1ps
module flush_engine_tb_top;
  localparam int MAC_W = 48;
  localparam int EXT_PORTS = 2;
  localparam int ENTRIES = 16;
  localparam int PMW = 3;
  localparam int W = 56;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, busy, done, rd_en, wr_en;
  logic [PMW-1:0] mask;
  logic [IW-1:0] addr;
  logic [W-1:0] rd_data, wr_data;

  flush_engine #(.MAC_W(MAC_W), .EXT_PORTS(EXT_PORTS), .ENTRIES(ENTRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_start(start), .flush_mask(mask),
    .flush_busy(busy), .flush_done(done), .tbl_addr(addr), .tbl_rd_en(rd_en),
    .tbl_rd_data(rd_data), .tbl_wr_en(wr_en), .tbl_wr_data(wr_data));

  // table model with a preload path and a write counter per index
  logic [W-1:0] mem [ENTRIES];
  int wcnt [ENTRIES];
  logic ld_en, clr;
  logic [IW-1:0] ld_addr;
  logic [W-1:0] ld_data;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (wr_en) mem[addr] <= wr_data;
    if (rd_en) rd_data <= mem[addr];
    for (int k = 0; k < ENTRIES; k++) if (clr) wcnt[k] <= 0;
    if (!clr && wr_en) wcnt[addr] <= wcnt[addr] + 1;
  end

  // row: kind[12:11] grp[10] members[9:7] owner[6:5] exp_kind[4:3] exp_members[2:0]
  localparam logic [12:0] VEC [ENTRIES] = '{
    {2'd0, 1'b0, 3'b000, 2'd0, 2'd0, 3'b000},
    {2'd1, 1'b0, 3'b000, 2'd0, 2'd0, 3'b000},
    {2'd1, 1'b0, 3'b000, 2'd1, 2'd1, 3'b000},
    {2'd3, 1'b0, 3'b000, 2'd0, 2'd0, 3'b000},
    {2'd2, 1'b0, 3'b000, 2'd0, 2'd2, 3'b000},
    {2'd1, 1'b1, 3'b011, 2'd0, 2'd1, 3'b010},
    {2'd1, 1'b1, 3'b101, 2'd0, 2'd0, 3'b101},
    {2'd1, 1'b1, 3'b110, 2'd0, 2'd1, 3'b110},
    {2'd3, 1'b1, 3'b001, 2'd0, 2'd3, 3'b000},
    {2'd1, 1'b1, 3'b111, 2'd0, 2'd1, 3'b110},
    {2'd1, 1'b0, 3'b000, 2'd2, 2'd1, 3'b000},
    {2'd1, 1'b0, 3'b000, 2'd3, 2'd1, 3'b000},
    {2'd3, 1'b1, 3'b111, 2'd0, 2'd3, 3'b110},
    {2'd1, 1'b0, 3'b000, 2'd0, 2'd0, 3'b000},
    {2'd0, 1'b1, 3'b111, 2'd0, 2'd0, 3'b111},
    {2'd1, 1'b1, 3'b100, 2'd0, 2'd1, 3'b100}
  };

  int n_tests = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(input logic [12:0] v, input int idx);
    return {v[6:5], v[9:7], v[10], v[12:11], 48'hA0_0000_0000 + 48'(idx)};
  endfunction

  task automatic run_flush(input logic [PMW-1:0] m, input bit poke);
    int n;
    int guard;
    n = 0;
    guard = 0;
    start = 1'b1;
    mask = m;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    while (!done && guard < 500) begin
      if (busy) n++;
      if (poke && n == 5) begin start = 1'b1; mask = 3'b111; end
      else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check(done && !busy, "R8 done while idle", {busy, done}, 64'b01);
    check(n == 2 * ENTRIES, "R8 busy cycles", 64'(n), 64'(2 * ENTRIES));
    @(negedge clk);
    check(!done, "R8 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #200us;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] e;
    string tag;
    rst_n = 1'b0; start = 1'b0; mask = '0; ld_en = 1'b0; clr = 1'b0;
    ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R10 reset state",
          {busy, done, rd_en, wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < ENTRIES; i++) begin
      ld_en = 1'b1; ld_addr = IW'(i); ld_data = mk(VEC[i], i);
      @(negedge clk);
    end
    ld_en = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;

    run_flush(3'b001, 1'b0);

    for (int i = 0; i < ENTRIES; i++) begin
      bit exam;
      e = mem[i];
      exam = (VEC[i][12:11] == 2'd1) || (VEC[i][12:11] == 2'd3);
      if (!exam) tag = "R1";
      else if (!VEC[i][10]) tag = "R2";
      else if (VEC[i][4:3] == 2'd0) tag = "R5 R6";
      else if (VEC[i][2:0] == 3'b000) tag = "R11";
      else if (VEC[i][2:0] == VEC[i][9:7]) tag = "R3";
      else tag = "R4";
      check({e[49:48], e[53:51]} == {VEC[i][4:3], VEC[i][2:0]},
            $sformatf("%s row %0d kind/members", tag, i),
            64'({e[49:48], e[53:51]}), 64'({VEC[i][4:3], VEC[i][2:0]}));
      check((e[47:0] == 48'hA0_0000_0000 + 48'(i)) && e[50] == VEC[i][10] &&
            e[55:54] == VEC[i][6:5] && wcnt[i] == (exam ? 1 : 0),
            $sformatf("R7 row %0d fields kept, write count", i),
            64'(wcnt[i]), 64'(exam ? 1 : 0));
    end

    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    run_flush(3'b010, 1'b1);

    e = mem[5];
    check(e[49:48] == 2'd1 && e[53:51] == 3'b000, "R11 second pass empties list",
          64'({e[49:48], e[53:51]}), 64'({2'd1, 3'b000}));
    e = mem[9];
    check(e[49:48] == 2'd0 && e[53:51] == 3'b110, "R5 second pass host only",
          64'({e[49:48], e[53:51]}), 64'({2'd0, 3'b110}));
    e = mem[2];
    check(e[49:48] == 2'd0, "R2 owner 1 freed", 64'(e[49:48]), 64'd0);
    e = mem[12];
    check(e[49:48] == 2'd0 && e[53:51] == 3'b110, "R5 vlan-addr host only",
          64'({e[49:48], e[53:51]}), 64'({2'd0, 3'b110}));
    e = mem[15];
    check(e[49:48] == 2'd1 && e[53:51] == 3'b100, "R9 late start ignored (mcast)",
          64'({e[49:48], e[53:51]}), 64'({2'd1, 3'b100}));
    e = mem[10];
    check(e[49:48] == 2'd1, "R9 late start ignored (ucast owner 2)",
          64'(e[49:48]), 64'd1);
    check(wcnt[0] == 0 && wcnt[4] == 0 && wcnt[14] == 0, "R1 no write to skipped",
          64'(wcnt[0] + wcnt[4] + wcnt[14]), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule